// File: doc/BRIEF.md
# IDE PIO Channel with Posted Writes and Read-Ahead

This block sits between a 32-bit host register port and one 16-bit IDE drive bus running programmed I/O. Host writes to the drive data register go into a four-entry, 32-bit buffer and are acknowledged at once. A strobe sequencer then drains each entry as two 16-bit drive writes. A host read of the data register switches the same buffer into read-ahead mode. The channel keeps fetching drive words, two per entry, until the buffer is full, and each host read takes one entry.

Accesses to the command-block registers are not buffered. Each one waits until every posted write has reached the drive, then runs as a single drive cycle, and the host is acknowledged only when that cycle finishes. Two timing sets, each an active count and a recovery count in host clocks, govern these cycles. One set serves the data register and the other serves the command block.

With a 50 MHz host clock, PIO mode 3 (180 ns cycle, about 11 MB/s) needs an active count of 4 and a recovery count of 4. Slower modes take larger counts, up to a 31-clock cycle.

Top module: `ide_pio_chan`

## Requirements
- R1: During and right after reset, both drive strobes and the drive chip select are high, the drive data output enable is low, and the host ready is low.
- R2: A data-register write (hst_is_data=1, hst_wr=1) is acknowledged in the same cycle it is requested, as long as the buffer has a free entry. Four such writes in a row are accepted with no wait.
- R3: When all four entries hold unwritten data, a further data write sees ready low until one entry has been fully written to the drive.
- R4: Each buffered 32-bit word reaches the drive as two write cycles at drive address 0. Bits 15:0 go first, then bits 31:16, and words leave in the order they were accepted.
- R5: A strobe stays low for exactly A host clocks. A is the data active count for data-register cycles and the command active count for command-block cycles, and a count of 0 acts as 1. The read and write strobes are never low together.
- R6: Between two strobes both strobes stay high for at least R+1 host clocks. R is the recovery count of the earlier cycle's timing set, and 0 acts as 1.
- R7: A command-block read or write starts its drive cycle only after all posted data writes have been written to the drive. The host is acknowledged after that cycle, and a read returns the drive's 16 bits zero-extended to 32.
- R8: A data read issued while posted writes are pending starts fetching only after those writes are on the drive.
- R9: The first data read fetches drive words into entries, first word in bits 15:0 and second word in bits 31:16, and returns the oldest entry. Fetching continues until four entries are held and then stops. Each entry the host takes lets two more drive reads run.
- R10: A command-block write discards all read-ahead data. The next data read returns words fetched from the drive after that write.
- R11: A data write while read-ahead data is held discards that data and is then posted normally. The next data read returns freshly fetched words.
- R12: Throughout each drive cycle, chip select is low and the address lines hold the cycle's address: 0 for data-register cycles and hst_addr for command-block cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, held until ready |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_is_data | input | 1 | 1 = drive data register, 0 = command block |
| hst_addr | input | 3 | Command-block register index |
| hst_wdata | input | 32 | Host write data |
| hst_rdy | output | 1 | Access completes in this cycle |
| hst_rdata | output | 32 | Host read data, valid with ready |
| cfg_dat_act | input | 4 | Strobe-active clocks, data register |
| cfg_dat_rec | input | 4 | Recovery clocks, data register |
| cfg_cmd_act | input | 4 | Strobe-active clocks, command block |
| cfg_cmd_rec | input | 4 | Recovery clocks, command block |
| ide_da | output | 3 | Drive register address |
| ide_cs_n | output | 1 | Drive chip select, active low |
| ide_rd_n | output | 1 | Drive read strobe, active low |
| ide_wr_n | output | 1 | Drive write strobe, active low |
| ide_dout | output | 16 | Drive write data |
| ide_doe | output | 1 | Drive data output enable |
| ide_din | input | 16 | Drive read data |

## Verification
A stuck half-select or buffer pointer shows up on the very next drive cycle. It appears as a swapped or repeated 16-bit word on the drive write data, or as a host read word whose halves or order do not match the drive's numbered read sequence. A wrong mode or flush decision shows up as the drive read count overshooting or stopping short of ten after a read. It can also show up as a stale word returned after a command write, both seen within one idle interval. Counter errors in the sequencer change the measured strobe width or recovery gap on the first cycle that uses the affected timing set.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACT  = 2'd1,
    SQ_REC  = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_DRAIN = 2'd1,
    OP_FETCH = 2'd2,
    OP_CMD   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_BUSY = 2'd1,
    CP_DONE = 2'd2
  } cmd_ph_e;

endpackage

// File: rtl/ide_pio_fifo.sv
module ide_pio_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d;
  logic [AW-1:0] rd_ptr, rd_ptr_d;
  logic [CW-1:0] cnt, cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt_d = cnt + 1'b1;
      else if (pop && !push) cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic load;
    assign load = push && !flush && (wr_ptr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem[i] <= '0;
      else if (load) mem[i] <= push_data;
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/ide_pio_strobe_seq.sv
module ide_pio_strobe_seq
  import ide_pio_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 3,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DW-1:0]     op_wdata,
  input  logic [CNT_W-1:0]  act_cnt,
  input  logic [CNT_W-1:0]  rec_cnt,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic [ADDR_W-1:0] ide_da,
  output logic              ide_cs_n,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [DW-1:0]     ide_dout,
  output logic              ide_doe,
  input  logic [DW-1:0]     ide_din
);
  seq_st_e           st, st_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic [CNT_W-1:0]  rec_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;
  logic              load, capture;
  logic [CNT_W-1:0]  act_m1, rec_m1;

  // a programmed zero behaves as one clock
  assign act_m1 = (act_cnt == '0) ? '0 : act_cnt - 1'b1;
  assign rec_m1 = (rec_cnt == '0) ? '0 : rec_cnt - 1'b1;

  always_comb begin
    st_d    = st;
    cnt_d   = cnt;
    load    = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_ACT;
          cnt_d = act_m1;
          load  = 1'b1;
        end
      end
      SQ_ACT: begin
        if (cnt == '0) begin
          st_d    = SQ_REC;
          cnt_d   = rec_q;
          capture = !wr_q;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      SQ_REC: begin
        if (cnt == '0) begin
          st_d = SQ_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_d;
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      rec_q   <= rec_m1;
      wr_q    <= op_wr;
      addr_q  <= op_addr;
      wdata_q <= op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= ide_din;
  end

  assign busy     = (st != SQ_IDLE);
  assign rdata    = rdata_q;
  assign ide_da   = addr_q;
  assign ide_dout = wdata_q;
  assign ide_cs_n = (st == SQ_IDLE);
  assign ide_doe  = (st != SQ_IDLE) && wr_q;
  assign ide_rd_n = !((st == SQ_ACT) && !wr_q);
  assign ide_wr_n = !((st == SQ_ACT) && wr_q);

endmodule

// File: rtl/ide_pio_chan.sv
module ide_pio_chan
  import ide_pio_pkg::*;
#(
  parameter int HDW       = 32,
  parameter int ADDR_W    = 3,
  parameter int TCNT_W    = 4,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_req,
  input  logic              hst_wr,
  input  logic              hst_is_data,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [HDW-1:0]    hst_wdata,
  output logic              hst_rdy,
  output logic [HDW-1:0]    hst_rdata,
  input  logic [TCNT_W-1:0] cfg_dat_act,
  input  logic [TCNT_W-1:0] cfg_dat_rec,
  input  logic [TCNT_W-1:0] cfg_cmd_act,
  input  logic [TCNT_W-1:0] cfg_cmd_rec,
  output logic [ADDR_W-1:0] ide_da,
  output logic              ide_cs_n,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [HDW/2-1:0]  ide_dout,
  output logic              ide_doe,
  input  logic [HDW/2-1:0]  ide_din
);
  localparam int IDW = HDW / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // buffer
  logic           buf_push, buf_pop, buf_flush;
  logic [HDW-1:0] buf_push_data, buf_head;
  logic           buf_full, buf_empty;

  ide_pio_fifo #(.DW(HDW), .DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .push      (buf_push),
    .push_data (buf_push_data),
    .pop       (buf_pop),
    .flush     (buf_flush),
    .head      (buf_head),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  // sequencer
  logic              seq_start, seq_busy, seq_done, seq_op_wr;
  logic [ADDR_W-1:0] seq_addr;
  logic [IDW-1:0]    seq_wdata, seq_rdata;
  logic [TCNT_W-1:0] seq_act, seq_rec;

  ide_pio_strobe_seq #(.CNT_W(TCNT_W), .ADDR_W(ADDR_W), .DW(IDW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (seq_start),
    .op_wr    (seq_op_wr),
    .op_addr  (seq_addr),
    .op_wdata (seq_wdata),
    .act_cnt  (seq_act),
    .rec_cnt  (seq_rec),
    .busy     (seq_busy),
    .done     (seq_done),
    .rdata    (seq_rdata),
    .ide_da   (ide_da),
    .ide_cs_n (ide_cs_n),
    .ide_rd_n (ide_rd_n),
    .ide_wr_n (ide_wr_n),
    .ide_dout (ide_dout),
    .ide_doe  (ide_doe),
    .ide_din  (ide_din)
  );

  // control state
  logic           rd_mode, rd_mode_d;
  logic           half, half_d;
  logic [IDW-1:0] lo_q, lo_d;
  op_kind_e       kind, kind_d;
  cmd_ph_e        cmd_ph, cmd_ph_d;
  logic [IDW-1:0] cmd_rd_q, cmd_rd_d;

  logic req_dwr, req_drd, req_cmd;
  logic go_cmd, go_drain, go_fetch;
  logic dwr_ok, drd_ok, cmd_ok;
  logic to_rd, to_wr;

  assign req_dwr = hst_req &&  hst_wr && hst_is_data;
  assign req_drd = hst_req && !hst_wr && hst_is_data;
  assign req_cmd = hst_req && !hst_is_data;

  // launch arbitration, only while the sequencer is idle
  assign go_cmd   = req_cmd && (cmd_ph == CP_IDLE) && !seq_busy && (rd_mode || buf_empty);
  assign go_drain = !rd_mode && !buf_empty && !seq_busy;
  assign go_fetch = rd_mode && !buf_full && !seq_busy && !req_cmd && !req_dwr;

  assign to_rd = req_drd && !rd_mode && buf_empty && !seq_busy;
  assign to_wr = req_dwr && rd_mode && !seq_busy;

  assign dwr_ok = req_dwr && !rd_mode && !buf_full;
  assign drd_ok = req_drd && rd_mode && !buf_empty;
  assign cmd_ok = req_cmd && (cmd_ph == CP_DONE);

  assign hst_rdy   = dwr_ok || drd_ok || cmd_ok;
  assign hst_rdata = drd_ok ? buf_head : {{(HDW-IDW){1'b0}}, cmd_rd_q};

  always_comb begin
    seq_start = go_cmd || go_drain || go_fetch;
    seq_op_wr = go_cmd ? hst_wr : go_drain;
    seq_addr  = go_cmd ? hst_addr : '0;
    if (go_cmd)    seq_wdata = hst_wdata[IDW-1:0];
    else if (half) seq_wdata = buf_head[HDW-1:IDW];
    else           seq_wdata = buf_head[IDW-1:0];
    seq_act = go_cmd ? cfg_cmd_act : cfg_dat_act;
    seq_rec = go_cmd ? cfg_cmd_rec : cfg_dat_rec;
  end

  always_comb begin
    rd_mode_d     = rd_mode;
    half_d        = half;
    lo_d          = lo_q;
    kind_d        = kind;
    cmd_ph_d      = cmd_ph;
    cmd_rd_d      = cmd_rd_q;
    buf_push      = dwr_ok;
    buf_push_data = hst_wdata;
    buf_pop       = drd_ok;
    buf_flush     = 1'b0;

    if (go_cmd)        kind_d = OP_CMD;
    else if (go_drain) kind_d = OP_DRAIN;
    else if (go_fetch) kind_d = OP_FETCH;

    if (seq_done) begin
      unique case (kind)
        OP_DRAIN: begin
          buf_pop = half;
          half_d  = !half;
        end
        OP_FETCH: begin
          if (half) begin
            buf_push      = 1'b1;
            buf_push_data = {seq_rdata, lo_q};
          end else begin
            lo_d = seq_rdata;
          end
          half_d = !half;
        end
        OP_CMD: begin
          cmd_rd_d = seq_rdata;
          cmd_ph_d = CP_DONE;
        end
        default: ;
      endcase
    end

    if (go_cmd) begin
      cmd_ph_d = CP_BUSY;
      if (hst_wr && rd_mode) begin
        buf_flush = 1'b1;
        rd_mode_d = 1'b0;
        half_d    = 1'b0;
      end
    end
    if (cmd_ok) cmd_ph_d = CP_IDLE;

    if (to_rd) begin
      rd_mode_d = 1'b1;
      half_d    = 1'b0;
    end
    if (to_wr) begin
      buf_flush = 1'b1;
      rd_mode_d = 1'b0;
      half_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_mode  <= 1'b0;
      half     <= 1'b0;
      lo_q     <= '0;
      kind     <= OP_NONE;
      cmd_ph   <= CP_IDLE;
      cmd_rd_q <= '0;
    end else begin
      rd_mode  <= rd_mode_d;
      half     <= half_d;
      lo_q     <= lo_d;
      kind     <= kind_d;
      cmd_ph   <= cmd_ph_d;
      cmd_rd_q <= cmd_rd_d;
    end
  end

endmodule

// File: rtl/ide_pio_chan_chk.sv
module ide_pio_chan_chk #(
  parameter int ADDR_W = 3,
  parameter int IDW    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] da,
  input logic [IDW-1:0]    dout,
  input logic              req,
  input logic              wr,
  input logic              is_data,
  input logic              rdy,
  input logic              buf_full,
  input logic              buf_empty,
  input logic              rd_mode
);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_wdata_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(dout));

  assert_addr_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable(da));

  assert_recovery_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |=> (rd_n && wr_n));

  assert_no_accept_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && is_data && rdy) |-> !buf_full);

  assert_read_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && is_data && rdy) |-> (rd_mode && !buf_empty));

endmodule

bind ide_pio_chan ide_pio_chan_chk #(.ADDR_W(ADDR_W), .IDW(HDW/2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .rd_n      (ide_rd_n),
  .wr_n      (ide_wr_n),
  .da        (ide_da),
  .dout      (ide_dout),
  .req       (hst_req),
  .wr        (hst_wr),
  .is_data   (hst_is_data),
  .rdy       (hst_rdy),
  .buf_full  (buf_full),
  .buf_empty (buf_empty),
  .rd_mode   (rd_mode)
);

// File: tb/ide_pio_chan_tb.sv
`timescale 1ns/1ps
module ide_pio_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_req, hst_wr, hst_is_data;
  logic [2:0]  hst_addr;
  logic [31:0] hst_wdata;
  logic        hst_rdy;
  logic [31:0] hst_rdata;
  logic [3:0]  cfg_dat_act, cfg_dat_rec, cfg_cmd_act, cfg_cmd_rec;
  logic [2:0]  ide_da;
  logic        ide_cs_n, ide_rd_n, ide_wr_n, ide_doe;
  logic [15:0] ide_dout;
  logic [15:0] ide_din;

  always #10 clk = ~clk;

  ide_pio_chan u_dut (
    .clk(clk), .rst_n(rst_n),
    .hst_req(hst_req), .hst_wr(hst_wr), .hst_is_data(hst_is_data),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdy(hst_rdy), .hst_rdata(hst_rdata),
    .cfg_dat_act(cfg_dat_act), .cfg_dat_rec(cfg_dat_rec),
    .cfg_cmd_act(cfg_cmd_act), .cfg_cmd_rec(cfg_cmd_rec),
    .ide_da(ide_da), .ide_cs_n(ide_cs_n), .ide_rd_n(ide_rd_n),
    .ide_wr_n(ide_wr_n), .ide_dout(ide_dout), .ide_doe(ide_doe),
    .ide_din(ide_din)
  );

  int n_chk = 0;
  int n_fail = 0;

  // drive-side log of every strobe
  int          ev_idx = 0;
  logic        ev_wr   [512];
  logic [2:0]  ev_da   [512];
  logic [15:0] ev_dout [512];
  logic        ev_cs   [512];
  int          ev_low  [512];
  int          ev_gap  [512];
  int          rd_cnt = 0;
  int          low_len = 0;
  int          hi_len = 99;
  logic        prev_strobe = 1'b0;

  always @(negedge clk) begin
    logic s;
    s = !ide_rd_n || !ide_wr_n;
    if (s && !prev_strobe) begin
      if (ev_idx < 512) begin
        ev_wr[ev_idx]   = !ide_wr_n;
        ev_da[ev_idx]   = ide_da;
        ev_dout[ev_idx] = ide_dout;
        ev_cs[ev_idx]   = !ide_cs_n;
        ev_gap[ev_idx]  = hi_len;
        ev_low[ev_idx]  = 0;
        ev_idx++;
      end
      if (!ide_rd_n) begin
        ide_din = 16'hA000 + 16'(rd_cnt);
        rd_cnt++;
      end
      low_len = 1;
    end else if (s) begin
      low_len++;
    end else if (prev_strobe) begin
      if (ev_idx > 0) ev_low[ev_idx-1] = low_len;
      hi_len = 1;
    end else begin
      hi_len++;
    end
    prev_strobe = s;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic host_xfer(input logic wr, input logic isd, input logic [2:0] a,
                           input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    hst_req = 1'b1; hst_wr = wr; hst_is_data = isd; hst_addr = a; hst_wdata = wd;
    waits = 0;
    #1;
    while (!hst_rdy && waits < 5000) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = hst_rdata;
    if (waits >= 5000) chk(1'b0, "host handshake timeout", 32'(waits), 32'd0);
    @(posedge clk);
    #1;
    hst_req = 1'b0;
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] rdword(input int n);
    return {16'hA000 + 16'(n + 1), 16'hA000 + 16'(n)};
  endfunction

  task automatic t_reset;
    chk_eq("R1 rd strobe", 32'(ide_rd_n), 32'd1);
    chk_eq("R1 wr strobe", 32'(ide_wr_n), 32'd1);
    chk_eq("R1 chip select", 32'(ide_cs_n), 32'd1);
    chk_eq("R1 output enable", 32'(ide_doe), 32'd0);
    chk_eq("R1 host ready", 32'(hst_rdy), 32'd0);
  endtask

  task automatic t_posted_write;
    int e0, w;
    logic [31:0] rd;
    e0 = ev_idx;
    for (int i = 0; i < 4; i++) begin
      host_xfer(1'b1, 1'b1, 3'd0, {16'hB000 + 16'(i), 16'h0A00 + 16'(i)}, rd, w);
      chk_eq("R2 posted write wait", 32'(w), 32'd0);
    end
    quiet(200);
    chk_eq("R4 drive write count", 32'(ev_idx - e0), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk_eq("R4 drive write data", 32'(ev_dout[e0+k]),
             (k % 2 == 0) ? 32'(16'h0A00 + 16'(k/2)) : 32'(16'hB000 + 16'(k/2)));
      chk_eq("R4 write strobe", 32'(ev_wr[e0+k]), 32'd1);
      chk_eq("R12 data address", 32'(ev_da[e0+k]), 32'd0);
      chk_eq("R5 data strobe width", 32'(ev_low[e0+k]), 32'd3);
      if (k > 0) chk(ev_gap[e0+k] >= 3, "R6 data recovery gap", 32'(ev_gap[e0+k]), 32'd3);
    end
  endtask

  task automatic t_full_holdoff;
    int e0, w;
    logic [31:0] rd;
    cfg_dat_act = 4'd15; cfg_dat_rec = 4'd15;
    e0 = ev_idx;
    for (int i = 0; i < 5; i++) begin
      host_xfer(1'b1, 1'b1, 3'd0, {16'hD000 + 16'(i), 16'h0D00 + 16'(i)}, rd, w);
      if (i < 4) chk_eq("R2 write into free entry", 32'(w), 32'd0);
      else       chk(w > 20, "R3 full buffer holds write", 32'(w), 32'd21);
    end
    quiet(450);
    chk_eq("R3 all entries written", 32'(ev_idx - e0), 32'd10);
    chk_eq("R4 fifth word low", 32'(ev_dout[e0+8]), 32'h0D04);
    chk_eq("R4 fifth word high", 32'(ev_dout[e0+9]), 32'hD004);
    chk_eq("R5 long strobe width", 32'(ev_low[e0+9]), 32'd15);
    chk(ev_gap[e0+9] >= 16, "R6 long recovery", 32'(ev_gap[e0+9]), 32'd16);
    cfg_dat_act = 4'd3; cfg_dat_rec = 4'd2;
  endtask

  task automatic t_cmd_order;
    int e0, w, nr;
    logic [31:0] rd;
    e0 = ev_idx;
    nr = rd_cnt;
    host_xfer(1'b1, 1'b1, 3'd0, 32'h2222_1111, rd, w);
    host_xfer(1'b1, 1'b1, 3'd0, 32'h4444_3333, rd, w);
    host_xfer(1'b1, 1'b0, 3'd3, 32'h0000_00C3, rd, w);
    chk(w > 0, "R7 command write waits for drain", 32'(w), 32'd1);
    host_xfer(1'b0, 1'b0, 3'd5, 32'h0, rd, w);
    chk_eq("R7 command read data", rd, {16'h0000, 16'hA000 + 16'(nr)});
    quiet(100);
    chk_eq("R7 cycle count", 32'(ev_idx - e0), 32'd6);
    for (int k = 0; k < 4; k++) begin
      chk_eq("R7 posted writes first", 32'(ev_da[e0+k]), 32'd0);
      chk_eq("R7 posted writes are writes", 32'(ev_wr[e0+k]), 32'd1);
    end
    chk_eq("R12 command write address", 32'(ev_da[e0+4]), 32'd3);
    chk_eq("R12 command write select", 32'(ev_cs[e0+4]), 32'd1);
    chk_eq("R7 command write data", 32'(ev_dout[e0+4]), 32'h00C3);
    chk_eq("R5 command strobe width", 32'(ev_low[e0+4]), 32'd5);
    chk(ev_gap[e0+4] >= 3, "R6 gap after data cycle", 32'(ev_gap[e0+4]), 32'd3);
    chk_eq("R12 command read address", 32'(ev_da[e0+5]), 32'd5);
    chk_eq("R7 command read is read", 32'(ev_wr[e0+5]), 32'd0);
    chk_eq("R5 command read width", 32'(ev_low[e0+5]), 32'd5);
    chk(ev_gap[e0+5] >= 5, "R6 gap after command cycle", 32'(ev_gap[e0+5]), 32'd5);
  endtask

  task automatic t_read_ahead;
    int e0, w, n0;
    logic [31:0] rd;
    e0 = ev_idx;
    n0 = rd_cnt;
    host_xfer(1'b1, 1'b1, 3'd0, 32'h1234_5678, rd, w);
    host_xfer(1'b0, 1'b1, 3'd0, 32'h0, rd, w);
    chk_eq("R9 first read word", rd, rdword(n0));
    chk_eq("R8 write before read 0", 32'(ev_wr[e0]), 32'd1);
    chk_eq("R8 write before read 1", 32'(ev_wr[e0+1]), 32'd1);
    chk_eq("R8 then read", 32'(ev_wr[e0+2]), 32'd0);
    quiet(200);
    chk_eq("R9 read-ahead stops when full", 32'(rd_cnt - n0), 32'd10);
    host_xfer(1'b0, 1'b1, 3'd0, 32'h0, rd, w);
    chk_eq("R9 second read word", rd, rdword(n0 + 2));
    chk_eq("R9 buffered read no wait", 32'(w), 32'd0);
    quiet(200);
    chk_eq("R9 refill after pop", 32'(rd_cnt - n0), 32'd12);
  endtask

  task automatic t_cmd_discards;
    int w, n1, nb;
    logic [31:0] rd;
    nb = rd_cnt;
    host_xfer(1'b1, 1'b0, 3'd2, 32'h0000_0077, rd, w);
    quiet(50);
    chk_eq("R10 no fetch after command write", 32'(rd_cnt), 32'(nb));
    n1 = rd_cnt;
    host_xfer(1'b0, 1'b1, 3'd0, 32'h0, rd, w);
    chk_eq("R10 fresh data after command write", rd, rdword(n1));
    quiet(200);
    chk_eq("R10 refetch count", 32'(rd_cnt - n1), 32'd10);
  endtask

  task automatic t_write_discards;
    int w, n2, e0;
    logic [31:0] rd;
    e0 = ev_idx;
    n2 = rd_cnt;
    host_xfer(1'b1, 1'b1, 3'd0, 32'h5555_AAAA, rd, w);
    quiet(100);
    chk_eq("R11 write cycles", 32'(ev_idx - e0), 32'd2);
    chk_eq("R11 low half written", 32'(ev_dout[ev_idx-2]), 32'hAAAA);
    chk_eq("R11 high half written", 32'(ev_dout[ev_idx-1]), 32'h5555);
    chk_eq("R11 no reads during write", 32'(rd_cnt), 32'(n2));
    host_xfer(1'b0, 1'b1, 3'd0, 32'h0, rd, w);
    chk_eq("R11 fresh data after write", rd, rdword(n2));
    quiet(200);
  endtask

  task automatic t_zero_counts;
    int w, e0;
    logic [31:0] rd;
    cfg_dat_act = 4'd0; cfg_dat_rec = 4'd0;
    e0 = ev_idx;
    host_xfer(1'b1, 1'b1, 3'd0, 32'hBEEF_0001, rd, w);
    quiet(50);
    chk_eq("R5 zero count cycles", 32'(ev_idx - e0), 32'd2);
    chk_eq("R5 zero active is one", 32'(ev_low[ev_idx-2]), 32'd1);
    chk_eq("R5 zero active is one hi", 32'(ev_low[ev_idx-1]), 32'd1);
    chk(ev_gap[ev_idx-1] >= 2, "R6 zero recovery is one", 32'(ev_gap[ev_idx-1]), 32'd2);
    chk_eq("R4 order under zero counts", 32'(ev_dout[ev_idx-1]), 32'hBEEF);
    cfg_dat_act = 4'd3; cfg_dat_rec = 4'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hst_req = 1'b0; hst_wr = 1'b0; hst_is_data = 1'b0;
    hst_addr = 3'd0; hst_wdata = 32'h0;
    cfg_dat_act = 4'd3; cfg_dat_rec = 4'd2;
    cfg_cmd_act = 4'd5; cfg_cmd_rec = 4'd4;
    ide_din = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_posted_write;
    t_full_holdoff;
    t_cmd_order;
    t_read_ahead;
    t_cmd_discards;
    t_write_discards;
    t_zero_counts;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule